// File: doc/BRIEF.md
# Event Priority Arbiter

This block sits beside an instruction sequencer and decides which pending event gets serviced when an instruction completes. The five sources, from most to least urgent, are:

1. a divide-error fault raised by the execution unit;
2. a software interrupt request carrying its own 8-bit type;
3. a non-maskable interrupt pin;
4. a maskable interrupt pin that is gated by an enable flag;
5. a single-step trap.

The sequencer pulses `boundary_i` for one clock when an instruction finishes. The block samples the sources on that edge and picks exactly one winner. In the next cycle it raises a single-cycle strobe, a one-hot code naming the winner and the 8-bit vector type to dispatch.

Sources that lose the arbitration are not cleared. The level-type sources stay asserted by their owners. The non-maskable request is held in an internal edge latch, which empties only when that request is granted. Every loser therefore competes again at the next boundary.

Top module: `irq_prio_arb`

## Requirements
- R1: When several sources are pending at a boundary, the winner follows this fixed order: divide error, software interrupt, non-maskable, maskable, single-step. `svc_src_o` is one-hot with bit 0 for divide error, bit 1 for software interrupt, bit 2 for non-maskable, bit 3 for maskable and bit 4 for single-step.
- R2: A serviced divide error reports vector type 0.
- R3: A serviced software interrupt reports the value of `swi_type_i` that was sampled at the boundary, unchanged, over the full range 0 to 255.
- R4: A serviced non-maskable request reports vector type 2, and the state of `intr_en_i` has no effect on it.
- R5: A rising edge on `nmi_i` is latched and gives exactly one service. Holding the pin high does not produce a second service. The edge must be seen on a clock before the boundary that is to take it.
- R6: A maskable request is considered only while `intr_en_i` is 1. It is taken as a level, so it is serviced at every boundary where it is high and wins. Its type is taken from `intr_type_i`.
- R7: A serviced single-step trap reports vector type 1.
- R8: A strobe is raised only in the cycle that follows a clock edge with `boundary_i` high and at least one request eligible. It lasts one cycle unless the next edge is also a boundary with a winner.
- R9: A non-maskable request that loses to a higher-priority source stays pending and is serviced at a later boundary.
- R10: During and after reset, `svc_o` is 0, `svc_src_o` is 0, `svc_type_o` is 0, and no non-maskable request is pending.
- R11: `svc_src_o` is nonzero exactly when `svc_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| boundary_i | input | 1 | Instruction-complete strobe; arbitration takes place on this edge |
| div_err_i | input | 1 | Divide-error fault request |
| swi_req_i | input | 1 | Software interrupt request |
| swi_type_i | input | 8 | Software interrupt type operand |
| nmi_i | input | 1 | Non-maskable interrupt pin, edge-latched |
| intr_i | input | 1 | Maskable interrupt pin, level |
| intr_en_i | input | 1 | Interrupt-enable flag for the maskable pin |
| intr_type_i | input | 8 | Vector type supplied for the maskable pin |
| step_i | input | 1 | Single-step trap request |
| svc_o | output | 1 | Service strobe |
| svc_type_o | output | 8 | Vector type of the granted event |
| svc_src_o | output | 5 | One-hot code of the granted source |

## Verification
The properties assume that every input is a clean synchronous level before reset is released and between clock edges. They also assume that `swi_type_i` and `intr_type_i` are valid on any edge where their requests are high. The bench drives every input only on falling clock edges and holds all inputs at 0 throughout reset. It raises each non-maskable edge at least one clock before the boundary that is meant to take it, so the one-cycle latch delay is never confused with a dropped request.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int unsigned NSRC   = 5;
  localparam int unsigned TYPE_W = 8;

  typedef logic [TYPE_W-1:0] vec_t;

  // bit index equals rank, 0 is most urgent
  typedef enum int unsigned {
    SRC_DIV  = 0,
    SRC_SWI  = 1,
    SRC_NMI  = 2,
    SRC_INTR = 3,
    SRC_STEP = 4
  } src_e;

  localparam vec_t VEC_DIV  = 8'd0;
  localparam vec_t VEC_STEP = 8'd1;
  localparam vec_t VEC_NMI  = 8'd2;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic grant_i,
  output logic pend_o
);
  logic pin_q;
  logic rise;

  assign rise = pin_i & ~pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q  <= 1'b0;
      pend_o <= 1'b0;
    end else begin
      pin_q <= pin_i;
      // a fresh edge outranks the clear from a grant
      if (rise)         pend_o <= 1'b1;
      else if (grant_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_rank
    assign gnt_o[i]     = req_i[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req_i[i];
  end
endmodule

// File: rtl/irq_vec_mux.sv
module irq_vec_mux #(
  parameter int unsigned N = 5,
  parameter int unsigned W = 8
) (
  input  logic [N-1:0]        sel_i,
  input  logic [N-1:0][W-1:0] vec_i,
  output logic [W-1:0]        vec_o
);
  logic [N:0][W-1:0] acc;

  assign acc[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_andor
    assign acc[i+1] = acc[i] | (vec_i[i] & {W{sel_i[i]}});
  end

  assign vec_o = acc[N];
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_arb_pkg::*;
#(
  parameter int unsigned TW = TYPE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          boundary_i,
  input  logic          div_err_i,
  input  logic          swi_req_i,
  input  logic [TW-1:0] swi_type_i,
  input  logic          nmi_i,
  input  logic          intr_i,
  input  logic          intr_en_i,
  input  logic [TW-1:0] intr_type_i,
  input  logic          step_i,
  output logic          svc_o,
  output logic [TW-1:0] svc_type_o,
  output logic [4:0]    svc_src_o
);
  localparam int unsigned N = NSRC;

  logic              nmi_pend;
  logic [N-1:0]      req;
  logic [N-1:0]      gnt;
  logic [N-1:0]      sel;
  logic [N-1:0][TW-1:0] vecs;
  logic [TW-1:0]     vec_win;

  irq_nmi_latch u_nmi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (nmi_i),
    .grant_i (sel[SRC_NMI]),
    .pend_o  (nmi_pend)
  );

  always_comb begin
    req            = '0;
    req[SRC_DIV]   = div_err_i;
    req[SRC_SWI]   = swi_req_i;
    req[SRC_NMI]   = nmi_pend;
    req[SRC_INTR]  = intr_i & intr_en_i;
    req[SRC_STEP]  = step_i;
  end

  irq_prio_pick #(.N(N)) u_pick (
    .req_i (req),
    .gnt_o (gnt)
  );

  assign sel = boundary_i ? gnt : '0;

  always_comb begin
    vecs           = '0;
    vecs[SRC_DIV]  = TW'(VEC_DIV);
    vecs[SRC_SWI]  = swi_type_i;
    vecs[SRC_NMI]  = TW'(VEC_NMI);
    vecs[SRC_INTR] = intr_type_i;
    vecs[SRC_STEP] = TW'(VEC_STEP);
  end

  irq_vec_mux #(.N(N), .W(TW)) u_mux (
    .sel_i (sel),
    .vec_i (vecs),
    .vec_o (vec_win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      svc_o      <= 1'b0;
      svc_src_o  <= '0;
      svc_type_o <= '0;
    end else begin
      svc_o     <= |sel;
      svc_src_o <= sel;
      if (|sel) svc_type_o <= vec_win;
    end
  end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       boundary_i,
  input logic       div_err_i,
  input logic       swi_req_i,
  input logic [7:0] swi_type_i,
  input logic       intr_i,
  input logic       intr_en_i,
  input logic       svc_o,
  input logic [7:0] svc_type_o,
  input logic [4:0] svc_src_o
);
  assert_src_onehot_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(svc_src_o));

  assert_div_top_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && div_err_i |=> svc_o && svc_src_o[0]);

  assert_div_vec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o && svc_src_o[0] |-> svc_type_o == 8'd0);

  assert_swi_vec_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && swi_req_i && !div_err_i |=> svc_src_o[1] && svc_type_o == $past(swi_type_i));

  assert_nmi_vec_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o && svc_src_o[2] |-> svc_type_o == 8'd2);

  assert_intr_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o && svc_src_o[3] |-> $past(intr_en_i) && $past(intr_i));

  assert_step_vec_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o && svc_src_o[4] |-> svc_type_o == 8'd1);

  assert_at_boundary_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o |-> $past(boundary_i));

  assert_strobe_code_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o == (svc_src_o != 5'd0));
endmodule

bind irq_prio_arb irq_arb_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .boundary_i (boundary_i),
  .div_err_i  (div_err_i),
  .swi_req_i  (swi_req_i),
  .swi_type_i (swi_type_i),
  .intr_i     (intr_i),
  .intr_en_i  (intr_en_i),
  .svc_o      (svc_o),
  .svc_type_o (svc_type_o),
  .svc_src_o  (svc_src_o)
);

// File: tb/irq_prio_arb_tb.sv
module irq_prio_arb_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       boundary = 1'b0, div_err = 1'b0, swi_req = 1'b0, nmi = 1'b0;
  logic       intr = 1'b0, intr_en = 1'b0, step = 1'b0;
  logic [7:0] swi_type = '0, intr_type = '0;
  logic       svc;
  logic [7:0] svc_type;
  logic [4:0] svc_src;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  irq_prio_arb u_dut (
    .clk_i(clk), .rst_ni(rst_n), .boundary_i(boundary), .div_err_i(div_err),
    .swi_req_i(swi_req), .swi_type_i(swi_type), .nmi_i(nmi), .intr_i(intr),
    .intr_en_i(intr_en), .intr_type_i(intr_type), .step_i(step),
    .svc_o(svc), .svc_type_o(svc_type), .svc_src_o(svc_src)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    div_err = 0; swi_req = 0; intr = 0; intr_en = 0; step = 0; boundary = 0;
  endtask

  // called at a negedge; outputs are valid at the following negedge
  task automatic arb();
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
  endtask

  task automatic expect_win(string req, int src, int typ);
    check({req, " strobe"}, svc, 1);
    check({req, " source"}, svc_src, src);
    check({req, " type"}, svc_type, typ);
  endtask

  task automatic nmi_edge();
    nmi = 1'b1;
    @(negedge clk);
    nmi = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 strobe", svc, 0);
    check("R10 source", svc_src, 0);
    check("R10 type", svc_type, 0);
    arb();
    check("R10 no nmi pending", svc, 0);
  endtask

  task automatic t_singles();
    div_err = 1; arb(); expect_win("R2", 5'b00001, 8'h00); idle();
    @(negedge clk);
    check("R11 idle source", svc_src, 0);
    check("R8 one-cycle strobe", svc, 0);
    swi_req = 1; swi_type = 8'hA5; arb(); expect_win("R3", 5'b00010, 8'hA5); idle();
    swi_req = 1; swi_type = 8'hFF; arb(); expect_win("R3 max", 5'b00010, 8'hFF); idle();
    intr = 1; intr_en = 1; intr_type = 8'h41; arb(); expect_win("R6", 5'b01000, 8'h41); idle();
    step = 1; arb(); expect_win("R7", 5'b10000, 8'h01); idle();
    nmi_edge(); arb(); expect_win("R4", 5'b00100, 8'h02);
  endtask

  task automatic t_priority();
    nmi_edge();
    div_err = 1; swi_req = 1; swi_type = 8'h30; intr = 1; intr_en = 1;
    intr_type = 8'h77; step = 1;
    arb(); expect_win("R1 div first", 5'b00001, 8'h00);
    div_err = 0; arb(); expect_win("R1 swi second", 5'b00010, 8'h30);
    swi_req = 0; arb(); expect_win("R9 nmi kept after losses", 5'b00100, 8'h02);
    arb(); expect_win("R1 intr fourth", 5'b01000, 8'h77);
    intr = 0; arb(); expect_win("R1 step last", 5'b10000, 8'h01);
    idle();
  endtask

  task automatic t_mask();
    intr = 1; intr_en = 0; intr_type = 8'h55; arb();
    check("R6 masked strobe", svc, 0);
    check("R6 masked source", svc_src, 0);
    step = 1; arb(); expect_win("R6 masked loses to step", 5'b10000, 8'h01);
    step = 0; nmi_edge(); arb(); expect_win("R4 ignores enable", 5'b00100, 8'h02);
    idle();
  endtask

  task automatic t_nmi_once();
    nmi = 1; @(negedge clk);
    arb(); expect_win("R5 first", 5'b00100, 8'h02);
    arb(); check("R5 held pin no repeat", svc, 0);
    nmi = 0; @(negedge clk);
    nmi_edge(); arb(); expect_win("R5 new edge", 5'b00100, 8'h02);
  endtask

  task automatic t_no_boundary();
    div_err = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 no boundary", svc, 0);
    end
    idle();
  endtask

  task automatic t_level();
    intr = 1; intr_en = 1; intr_type = 8'h12;
    arb(); expect_win("R6 level 1", 5'b01000, 8'h12);
    intr_type = 8'h13;
    arb(); expect_win("R6 level 2", 5'b01000, 8'h13);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_singles();
    t_priority();
    t_mask();
    t_nmi_once();
    t_no_boundary();
    t_level();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule